// File: doc/BRIEF.md
# Power Button Sequencing Controller

This block sits in an always-on domain that runs from a slow 32 kHz clock. It watches an active-low push-button and drives a power-request line to an external power supply device. No analog or mechanical debounce stage exists. The button is sampled by the slow clock, and the length of a press decides what happens.

While main power is off, a long enough press raises the power request. While power is on, the result depends on press length. A medium press, judged on release, sets an interrupt so that software can shut down in an orderly way. A very long press drops the power request in hardware and raises no interrupt. Software can also drop the power request through a request strobe, and it clears the interrupt with a write-one-to-clear strobe. A test-mode input turns the button function off.

Thresholds are parameters counted in clock cycles. The defaults are 24576 cycles (750 ms at 32768 Hz) and 163840 cycles (5 s).

Top module: `pwr_button_ctrl`

## Requirements
- R1: After the active-low asynchronous reset, `powerReq` and `irqPending` are both 0, and the block is in the power-off state.
- R2: While `powerReq` is 0, a press held for more than SHORT_CYC consecutive synchronized cycles sets `powerReq`. A press of SHORT_CYC cycles or fewer leaves it at 0.
- R3: While `powerReq` is 1, releasing a press that lasted more than SHORT_CYC and at most LONG_CYC synchronized cycles sets `irqPending`, and `powerReq` stays 1. A shorter press sets nothing.
- R4: While `powerReq` is 1, a press held for more than LONG_CYC synchronized cycles clears `powerReq`, and `irqPending` is not set. The press counter saturates and does not wrap.
- R5: A one-cycle pulse on `irqClear` clears `irqPending` on the next edge. A new interrupt in the same cycle takes priority over the clear.
- R6: While `testMode` is 1, presses have no effect on `powerReq` or `irqPending`.
- R7: After any change of `powerReq`, the button takes no further action until it has been seen released. One held press cannot both power up and power down.
- R8: A pulse on `swOffReq` while `powerReq` is 1 clears `powerReq` on the next edge.
- R9: The button passes through a two-flop synchronizer. When a press starts before clock edge E0, `powerReq` is still 0 after edge E0+SHORT_CYC+1 and is 1 after edge E0+SHORT_CYC+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rstN | input | 1 | Active-low asynchronous reset |
| buttonN | input | 1 | Push-button, low while pressed, asynchronous |
| testMode | input | 1 | High disables the button function |
| swOffReq | input | 1 | Software strobe requesting power removal |
| irqClear | input | 1 | Software write-one-to-clear strobe for the interrupt |
| powerReq | output | 1 | Power request to the external supply device |
| irqPending | output | 1 | Medium-press interrupt to the processor |

## Verification
A wrong press count shows up within one cycle of the threshold it affects. `powerReq` moves one cycle early or late, or a release at the window edges raises or misses `irqPending`. A re-arm flag that is stuck shows up only in a held press that crosses both thresholds: power comes up and then drops in that same press, or a fresh press is ignored. The bench therefore holds presses well past the long threshold after each state change. Because the reference model is compared on every clock, any such deviation is reported in the exact cycle where the output differs.

// File: rtl/pwr_button_pkg.sv
package pwr_button_pkg;
  // strobes from control into datapath
  typedef struct packed {
    logic cntEn;
  } dpCtrl_t;

  // qualified conditions from datapath to control
  typedef struct packed {
    logic pressed;
    logic atShort;
    logic atLong;
    logic released;
    logic midLen;
  } dpStat_t;
endpackage

// File: rtl/pwr_button_dp.sv
module pwr_button_dp
  import pwr_button_pkg::*;
#(
  parameter int SHORT_CYC = 24576,
  parameter int LONG_CYC  = 163840,
  parameter int CNT_W     = 18,
  parameter int SYNC_N    = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    buttonN,
  input  dpCtrl_t ctrl,
  output dpStat_t stat
);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SHORT_VAL = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] LONG_VAL  = CNT_W'(LONG_CYC);

  logic [SYNC_N-1:0] syncQ;
  logic [CNT_W-1:0]  pressCnt;
  logic              pressed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_N-2:0], buttonN};
  end

  assign pressed = ~syncQ[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         pressCnt <= '0;
    else if (!pressed || !ctrl.cntEn)  pressCnt <= '0;
    else if (pressCnt != CNT_MAX)      pressCnt <= pressCnt + 1'b1;
  end

  always_comb begin
    stat.pressed  = pressed;
    stat.atShort  = pressed && (pressCnt == SHORT_VAL);
    stat.atLong   = pressed && (pressCnt == LONG_VAL);
    stat.released = !pressed && (pressCnt != '0);
    stat.midLen   = (pressCnt > SHORT_VAL) && (pressCnt <= LONG_VAL);
  end

  // R4
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pressCnt == CNT_MAX && pressed && ctrl.cntEn) |=> (pressCnt == CNT_MAX || !pressed));

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pressed) |=> (pressCnt == '0));
endmodule

// File: rtl/pwr_button_ctl.sv
module pwr_button_ctl
  import pwr_button_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    testMode,
  input  logic    swOffReq,
  input  logic    irqClear,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    powerReq,
  output logic    irqPending
);
  logic armed;
  logic go, powerUp, forceDown, swOff, midIrq, stateChg;

  assign ctrl.cntEn = !testMode;

  always_comb begin
    go        = armed && !testMode;
    powerUp   = !powerReq && go && stat.atShort;
    forceDown = powerReq && go && stat.atLong;
    midIrq    = powerReq && go && stat.released && stat.midLen;
    swOff     = powerReq && swOffReq;
    stateChg  = powerUp || forceDown || swOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerReq   <= 1'b0;
      armed      <= 1'b1;
      irqPending <= 1'b0;
    end else begin
      if (swOff || forceDown) powerReq <= 1'b0;
      else if (powerUp)       powerReq <= 1'b1;

      if (stateChg)           armed <= 1'b0;
      else if (!stat.pressed) armed <= 1'b1;

      if (midIrq)             irqPending <= 1'b1;
      else if (irqClear)      irqPending <= 1'b0;
    end
  end

  // R8
  sw_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    swOffReq |=> !powerReq);

  // R4
  force_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerReq && stat.atLong && armed && !testMode) |=> (!powerReq && !$rose(irqPending)));

  // R6
  test_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !swOffReq) |=> ($stable(powerReq) && !$rose(irqPending)));

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !stat.released) |=> !irqPending);

  // R7
  rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerReq != $past(powerReq)) |-> !armed);
endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl
  import pwr_button_pkg::*;
#(
  parameter int SHORT_CYC = 24576,
  parameter int LONG_CYC  = 163840,
  parameter int CNT_W     = 18
) (
  input  logic clk,
  input  logic rstN,
  input  logic buttonN,
  input  logic testMode,
  input  logic swOffReq,
  input  logic irqClear,
  output logic powerReq,
  output logic irqPending
);
  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  pwr_button_dp #(
    .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .CNT_W(CNT_W), .SYNC_N(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .buttonN(buttonN), .ctrl(dpCtrl), .stat(dpStat)
  );

  pwr_button_ctl u_ctl (
    .clk(clk), .rstN(rstN), .testMode(testMode), .swOffReq(swOffReq),
    .irqClear(irqClear), .stat(dpStat), .ctrl(dpCtrl),
    .powerReq(powerReq), .irqPending(irqPending)
  );
endmodule

// File: tb/pwr_button_ctrl_tb.sv
module pwr_button_ctrl_tb;
  localparam int SHORT = 20;
  localparam int LONG  = 60;
  localparam int W     = 8;
  localparam int MAXC  = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buttonN = 1'b1;
  logic testMode = 1'b0;
  logic swOffReq = 1'b0;
  logic irqClear = 1'b0;
  logic powerReq, irqPending;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  pwr_button_ctrl #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .buttonN(buttonN), .testMode(testMode),
    .swOffReq(swOffReq), .irqClear(irqClear),
    .powerReq(powerReq), .irqPending(irqPending)
  );

  // behavioural reference model
  bit syncM[$] = '{1'b1, 1'b1};
  int cntM = 0;
  bit pwrM = 0, irqM = 0, armM = 1;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncM = '{1'b1, 1'b1}; cntM = 0; pwrM = 0; irqM = 0; armM = 1;
    end else begin
      bit p, en, go, up, dn, rel, irqSet, sw;
      p      = !syncM[0];
      en     = !testMode;
      go     = armM && en;
      up     = !pwrM && go && p && cntM == SHORT;
      dn     = pwrM && go && p && cntM == LONG;
      rel    = !p && cntM != 0;
      irqSet = pwrM && go && rel && cntM > SHORT && cntM <= LONG;
      sw     = pwrM && swOffReq;
      if (up || dn || sw) armM = 0; else if (!p) armM = 1;
      if (sw || dn) pwrM = 0; else if (up) pwrM = 1;
      if (irqSet) irqM = 1; else if (irqClear) irqM = 0;
      if (!p || !en) cntM = 0; else if (cntM < MAXC) cntM++;
      void'(syncM.pop_front());
      syncM.push_back(buttonN);
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R2 R3 R4 R5 R6 R7 R8 R9)
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(powerReq == pwrM, "R2/R4/R7/R8/R9", "model powerReq", powerReq, pwrM);
      chk(irqPending == irqM, "R3/R5/R6", "model irqPending", irqPending, irqM);
    end
  end

  task automatic press(int n);
    @(negedge clk) buttonN = 1'b0;
    repeat (n) @(negedge clk);
    buttonN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run hung", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(powerReq == 0, "R1", "reset powerReq", powerReq, 0);
    chk(irqPending == 0, "R1", "reset irqPending", irqPending, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    press(SHORT);
    chk(powerReq == 0, "R2", "press at threshold", powerReq, 0);

    // long hold from off: latency (R9), single action (R7)
    @(negedge clk) buttonN = 1'b0;
    repeat (SHORT + 2) @(posedge clk);
    @(negedge clk);
    chk(powerReq == 0, "R9", "one edge before rise", powerReq, 0);
    @(posedge clk); @(negedge clk);
    chk(powerReq == 1, "R9", "rise edge", powerReq, 1);
    chk(powerReq == 1, "R2", "power-up", powerReq, 1);
    repeat (3 * LONG) @(negedge clk);
    buttonN = 1'b1;
    repeat (6) @(negedge clk);
    chk(powerReq == 1, "R7", "held press no power-down", powerReq, 1);
    chk(irqPending == 0, "R7", "held press no irq", irqPending, 0);

    press(40);
    chk(irqPending == 1, "R3", "medium irq", irqPending, 1);
    chk(powerReq == 1, "R3", "medium keeps power", powerReq, 1);
    pulse(irqClear);
    chk(irqPending == 0, "R5", "clear", irqPending, 0);

    press(SHORT);
    chk(irqPending == 0, "R3", "short press no irq", irqPending, 0);
    press(LONG);
    chk(irqPending == 1, "R3", "upper bound irq", irqPending, 1);
    chk(powerReq == 1, "R3", "upper bound power", powerReq, 1);
    pulse(irqClear);
    press(LONG + 1);
    chk(powerReq == 0, "R4", "forced down", powerReq, 0);
    chk(irqPending == 0, "R4", "no irq on force", irqPending, 0);

    testMode = 1'b1;
    press(40);
    chk(powerReq == 0, "R6", "test mode off press", powerReq, 0);
    testMode = 1'b0;
    press(30);
    chk(powerReq == 1, "R2", "power-up again", powerReq, 1);
    testMode = 1'b1;
    press(40);
    press(LONG + 20);
    chk(powerReq == 1, "R6", "test mode on press", powerReq, 1);
    chk(irqPending == 0, "R6", "test mode no irq", irqPending, 0);
    testMode = 1'b0;

    pulse(swOffReq);
    chk(powerReq == 0, "R8", "software off", powerReq, 0);

    // software off during held press, then no re-power (R7)
    @(negedge clk) buttonN = 1'b0;
    repeat (30) @(negedge clk);
    chk(powerReq == 1, "R2", "up before sw off", powerReq, 1);
    swOffReq = 1'b1;
    @(negedge clk) swOffReq = 1'b0;
    chk(powerReq == 0, "R8", "sw off while held", powerReq, 0);
    repeat (2 * LONG) @(negedge clk);
    chk(powerReq == 0, "R7", "no re-power in same press", powerReq, 0);
    buttonN = 1'b1;
    repeat (6) @(negedge clk);

    finishRun();
  end
endmodule